// File: doc/BRIEF.md
# Privilege-Aware Interrupt Arbiter

This block sits beside a hart that runs in either machine or supervisor privilege and decides, every cycle, whether one of a small set of interrupt lines should be taken. Each line keeps a pending bit, which is set by a rising edge on its hardware input or by a software set pulse and cleared by a software clear pulse. Each line also has an enable bit, a two-bit target attribute and an eight-bit level. The arbiter splits the lines by target privilege. It gates each group with the global enable that applies in the hart's current privilege and filters each group against its own level threshold. A machine-targeted winner always beats a supervisor-targeted one.

The outputs are registered. They are a take strobe, a flag giving the target privilege of the winner, and the winner's exception code, which equals its line index. A separate wake output tells a stalled wait-for-interrupt that some enabled line is pending, whether or not that line can be taken. With the default configuration, line 3 serves as the software interrupt (code 3) and line 7 serves as the timer interrupt (code 7).

Top module: `clic_priv_arb`

## Requirements
- R1: A pending bit is set by a rising edge of its `irq_in` line or by `sw_set`, and is cleared by `sw_clr`. When set and clear arrive in the same cycle, set wins. Otherwise the bit holds, so an input held high does not set it again. Reset clears every pending bit.
- R2: A line's attribute 2'b11 targets machine privilege and 2'b01 targets supervisor privilege. Lines with attribute 2'b00 or 2'b10 are never taken.
- R3: A machine-targeted line can be taken whenever the hart is in supervisor privilege (`cur_priv`=0), whatever the value of `m_gie`. While the hart is in machine privilege (`cur_priv`=1), such a line can be taken only if `m_gie`=1.
- R4: A supervisor-targeted line is never taken while `cur_priv`=1. In supervisor privilege it can be taken only when `s_gie`=1.
- R5: A line whose `line_en` bit is 0 is never taken, and it does not raise `wake`.
- R6: When both groups have an eligible line, the machine-targeted line is taken, even if the supervisor line has a higher level.
- R7: Within one target group, the eligible line with the highest level wins. On equal levels, the higher line index wins.
- R8: A machine-targeted line is eligible only if its level is strictly greater than `m_thresh`. A supervisor-targeted line is eligible only if its level is strictly greater than `s_thresh`.
- R9: A pending line that is not cleared is taken again as soon as its global enable returns.
- R10: `wake` is 1 when any line is both pending and enabled, whatever the privilege, global enables, thresholds or attribute.
- R11: `take_code` is the index of the winning line. Software line 3 gives code 3 and timer line 7 gives code 7.
- R12: `take`, `take_mach`, `take_code` and `wake` are registered. They reflect the pending bits and inputs of the previous cycle, so a pending bit set at one edge produces `take` at the following edge.
- R13: During and right after reset, `take`, `wake` and all pending bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQ | Hardware lines; a rising edge sets the pending bit |
| sw_set | input | NUM_IRQ | Software set pulses for pending bits |
| sw_clr | input | NUM_IRQ | Software clear pulses for pending bits |
| line_en | input | NUM_IRQ | Per-line enables |
| line_attr | input | NUM_IRQ x 2 | Per-line target attribute (11 machine, 01 supervisor) |
| line_lvl | input | NUM_IRQ x CTL_W | Per-line level |
| cur_priv | input | 1 | Current hart privilege: 1 machine, 0 supervisor |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| m_thresh | input | CTL_W | Machine level threshold |
| s_thresh | input | CTL_W | Supervisor level threshold |
| pend_q | output | NUM_IRQ | Pending bits |
| take | output | 1 | An interrupt is taken |
| take_mach | output | 1 | Winner targets machine privilege |
| take_code | output | IDW | Exception code (line index) of the winner |
| wake | output | 1 | Some enabled line is pending |

## Verification
The hardest situations to reach from the ports are the ones where a line stays pending but must not be taken. These include a machine line masked only because the hart is in machine privilege, a supervisor line whose level equals its threshold, and an uncleared line that has to retrigger once its enable comes back. The stimulus reaches each of them by leaving one pending bit set and changing only the privilege, global enable or threshold inputs between observations. A behavioural model compares `take`, `wake` and the pending bits on every cycle, and directed checks mark each of these points.

// File: rtl/clic_arb_pkg.sv
package clic_arb_pkg;

    localparam int CTL_W = 8;

    typedef enum logic [1:0] {
        ATTR_RSVD_LO = 2'b00,
        ATTR_SUP     = 2'b01,
        ATTR_RSVD_HI = 2'b10,
        ATTR_MACH    = 2'b11
    } tgt_attr_e;

    typedef enum logic {
        PRIV_S = 1'b0,
        PRIV_M = 1'b1
    } priv_e;

    typedef struct packed {
        logic take;
        logic to_mach;
        logic wake;
    } arb_flags_t;

    // Privilege and threshold gate for one line of a known target group.
    function automatic logic gate_ok(
        input tgt_attr_e          attr,
        input priv_e              priv,
        input logic               m_gie,
        input logic               s_gie,
        input logic [CTL_W-1:0]   lvl,
        input logic [CTL_W-1:0]   m_th,
        input logic [CTL_W-1:0]   s_th
    );
        logic ok;
        ok = 1'b0;
        if (attr == ATTR_MACH)
            ok = ((priv == PRIV_S) || m_gie) && (lvl > m_th);
        else if (attr == ATTR_SUP)
            ok = (priv == PRIV_S) && s_gie && (lvl > s_th);
        return ok;
    endfunction

endpackage

// File: rtl/clic_pend_bank.sv
module clic_pend_bank #(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [NUM_IRQ-1:0] sw_set,
    input  logic [NUM_IRQ-1:0] sw_clr,
    output logic [NUM_IRQ-1:0] pend_q
);
    logic [NUM_IRQ-1:0] irq_prev;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        logic rise;
        assign rise = irq_in[i] & ~irq_prev[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                irq_prev[i] <= 1'b0;
                pend_q[i]   <= 1'b0;
            end else begin
                irq_prev[i] <= irq_in[i];
                pend_q[i]   <= (pend_q[i] & ~sw_clr[i]) | rise | sw_set[i];
            end
        end

        // R1
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            sw_set[i] |=> pend_q[i]);
        // R1
        clr_effect_chk: assert property (@(posedge clk) disable iff (rst)
            (sw_clr[i] && !sw_set[i] && !irq_in[i]) |=> !pend_q[i]);
    end
endmodule

// File: rtl/clic_mode_pick.sv
module clic_mode_pick #(
    parameter int NUM_IRQ = 8,
    parameter int LW      = 8,
    parameter int IW      = 3
) (
    input  logic [NUM_IRQ-1:0]         elig,
    input  logic [NUM_IRQ-1:0][LW-1:0] lvl,
    output logic                       hit,
    output logic [IW-1:0]              id
);
    logic [LW-1:0] best;

    // Ascending scan with >= lets a later (higher) index take ties.
    always_comb begin
        hit  = 1'b0;
        id   = '0;
        best = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (elig[i] && (!hit || lvl[i] >= best)) begin
                hit  = 1'b1;
                best = lvl[i];
                id   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/clic_priv_arb.sv
module clic_priv_arb
    import clic_arb_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    localparam int IDW    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_IRQ-1:0]            irq_in,
    input  logic [NUM_IRQ-1:0]            sw_set,
    input  logic [NUM_IRQ-1:0]            sw_clr,
    input  logic [NUM_IRQ-1:0]            line_en,
    input  logic [NUM_IRQ-1:0][1:0]       line_attr,
    input  logic [NUM_IRQ-1:0][CTL_W-1:0] line_lvl,
    input  logic                          cur_priv,
    input  logic                          m_gie,
    input  logic                          s_gie,
    input  logic [CTL_W-1:0]              m_thresh,
    input  logic [CTL_W-1:0]              s_thresh,
    output logic [NUM_IRQ-1:0]            pend_q,
    output logic                          take,
    output logic                          take_mach,
    output logic [IDW-1:0]                take_code,
    output logic                          wake
);
    localparam int N_GRP = 2;   // 0: supervisor group, 1: machine group

    logic [N_GRP-1:0][NUM_IRQ-1:0] grp_elig;
    logic [N_GRP-1:0]              grp_hit;
    logic [N_GRP-1:0][IDW-1:0]     grp_id;
    logic [NUM_IRQ-1:0]            live;
    arb_flags_t                    flags_d, flags_q;
    logic [IDW-1:0]                code_d, code_q;

    clic_pend_bank #(.NUM_IRQ(NUM_IRQ)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .irq_in (irq_in),
        .sw_set (sw_set),
        .sw_clr (sw_clr),
        .pend_q (pend_q)
    );

    assign live = pend_q & line_en;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_elig
        logic ok;
        assign ok = live[i] & gate_ok(tgt_attr_e'(line_attr[i]), priv_e'(cur_priv),
                                      m_gie, s_gie, line_lvl[i], m_thresh, s_thresh);
        assign grp_elig[1][i] = ok & (line_attr[i] == ATTR_MACH);
        assign grp_elig[0][i] = ok & (line_attr[i] == ATTR_SUP);
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_pick
        clic_mode_pick #(.NUM_IRQ(NUM_IRQ), .LW(CTL_W), .IW(IDW)) u_pick (
            .elig (grp_elig[g]),
            .lvl  (line_lvl),
            .hit  (grp_hit[g]),
            .id   (grp_id[g])
        );
    end

    always_comb begin
        flags_d.take    = |grp_hit;
        flags_d.to_mach = grp_hit[1];
        flags_d.wake    = |live;
        code_d          = grp_hit[1] ? grp_id[1] : grp_id[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            code_q  <= '0;
        end else begin
            flags_q <= flags_d;
            code_q  <= code_d;
        end
    end

    assign take      = flags_q.take;
    assign take_mach = flags_q.to_mach;
    assign take_code = code_q;
    assign wake      = flags_q.wake;

    // R4
    sup_priv_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !take_mach) |-> $past(cur_priv == 1'b0 && s_gie));
    // R3
    m_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_priv && !m_gie) |=> !take);
    // R10
    take_wake_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> wake);
    // R6
    mach_first_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !take_mach) |-> $past(!grp_hit[1]));
    // R5
    en_gate_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> $past(line_en[code_d] && pend_q[code_d]));
endmodule

// File: tb/tb_clic_priv_arb.sv
module tb_clic_priv_arb;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] irq_in = '0, sw_set = '0, sw_clr = '0, line_en = '0;
    logic [N-1:0][1:0] line_attr = '0;
    logic [N-1:0][7:0] line_lvl = '0;
    logic cur_priv = 1'b1, m_gie = 1'b0, s_gie = 1'b0;
    logic [7:0] m_thresh = '0, s_thresh = '0;
    logic [N-1:0] pend_q;
    logic take, take_mach, wake;
    logic [2:0] take_code;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    clic_priv_arb #(.NUM_IRQ(N)) dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .sw_set(sw_set), .sw_clr(sw_clr),
        .line_en(line_en), .line_attr(line_attr), .line_lvl(line_lvl),
        .cur_priv(cur_priv), .m_gie(m_gie), .s_gie(s_gie),
        .m_thresh(m_thresh), .s_thresh(s_thresh), .pend_q(pend_q),
        .take(take), .take_mach(take_mach), .take_code(take_code), .wake(wake)
    );

    // Behavioural reference model
    bit mp[N];
    bit mprev[N];
    bit e_take, e_mach, e_wake;
    int e_code;

    function automatic bit can_m(int i);
        return mp[i] && line_en[i] && line_attr[i] == 2'b11 &&
               (!cur_priv || m_gie) && (int'(line_lvl[i]) > int'(m_thresh));
    endfunction
    function automatic bit can_s(int i);
        return mp[i] && line_en[i] && line_attr[i] == 2'b01 &&
               !cur_priv && s_gie && (int'(line_lvl[i]) > int'(s_thresh));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin mp[i] = 0; mprev[i] = 0; end
            e_take = 0; e_mach = 0; e_code = 0; e_wake = 0;
        end else begin
            int bm, bs;
            bm = -1; bs = -1; e_wake = 0;
            for (int i = N - 1; i >= 0; i--) begin
                if (can_m(i) && (bm < 0 || line_lvl[i] > line_lvl[bm])) bm = i;
                if (can_s(i) && (bs < 0 || line_lvl[i] > line_lvl[bs])) bs = i;
                if (mp[i] && line_en[i]) e_wake = 1;
            end
            e_take = (bm >= 0) || (bs >= 0);
            e_mach = bm >= 0;
            e_code = (bm >= 0) ? bm : ((bs >= 0) ? bs : 0);
            for (int i = 0; i < N; i++) begin
                bit r;
                r = irq_in[i] && !mprev[i];
                mp[i] = (mp[i] && !sw_clr[i]) || r || sw_set[i];
                mprev[i] = irq_in[i];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            int pv;
            pv = 0;
            for (int i = 0; i < N; i++) pv |= int'(mp[i]) << i;
            chk(take == e_take, "MODEL take", take, e_take);
            chk(wake == e_wake, "MODEL wake", wake, e_wake);
            chk(int'(pend_q) == pv, "MODEL pend", pend_q, pv);
            if (e_take) begin
                chk(take_mach == e_mach, "MODEL mach", take_mach, e_mach);
                chk(int'(take_code) == e_code, "MODEL code", take_code, e_code);
            end
        end
    end

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask
    task automatic pset(input int i);
        sw_set[i] = 1'b1; @(negedge clk); sw_set[i] = 1'b0; @(negedge clk);
    endtask
    task automatic pclr(input int i);
        sw_clr[i] = 1'b1; @(negedge clk); sw_clr[i] = 1'b0; @(negedge clk);
    endtask
    task automatic expect_take(input string tag, input bit t, input bit m, input int c);
        chk(take == t, tag, take, t);
        if (t) begin
            chk(take_mach == m, tag, take_mach, m);
            chk(int'(take_code) == c, tag, take_code, c);
        end
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        chk(take == 0 && wake == 0 && pend_q == 0, "R13 reset", take, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(take == 0 && wake == 0 && pend_q == 0, "R13 after reset", take, 0);

        // R3/R11: machine line in supervisor privilege, m_gie=0
        line_en[3] = 1; line_attr[3] = 2'b11; line_lvl[3] = 200;
        cur_priv = 0; m_gie = 0;
        pset(3);
        expect_take("R3 m-line in S, m_gie=0", 1, 1, 3);
        chk(take_code == 3, "R11 software code", take_code, 3);
        cur_priv = 1; settle();
        expect_take("R3 m-line in M, m_gie=0", 0, 0, 0);
        chk(wake == 1, "R10 wake while masked", wake, 1);
        m_gie = 1; settle();
        expect_take("R3 m-line in M, m_gie=1", 1, 1, 3);
        pclr(3); @(negedge clk);
        chk(take == 0 && wake == 0, "R1 cleared", take, 0);

        // R4 supervisor line
        line_attr[3] = 2'b01; s_gie = 1; cur_priv = 1;
        pset(3); @(negedge clk);
        expect_take("R4 s-line in M", 0, 0, 0);
        cur_priv = 0; s_gie = 0; settle();
        expect_take("R4 s-line in S, s_gie=0", 0, 0, 0);
        s_gie = 1; settle();
        expect_take("R4 s-line in S, s_gie=1", 1, 0, 3);

        // R5 line enable
        line_en[3] = 0; settle();
        expect_take("R5 disabled line", 0, 0, 0);
        chk(wake == 0, "R5 no wake when disabled", wake, 0);
        line_en[3] = 1;

        // R6 machine beats higher-level supervisor
        line_lvl[3] = 255;
        line_en[7] = 1; line_attr[7] = 2'b11; line_lvl[7] = 1; m_thresh = 0;
        pset(7);
        expect_take("R6 machine first", 1, 1, 7);
        chk(take_code == 7, "R11 timer code", take_code, 7);
        pclr(7); @(negedge clk);
        expect_take("R6 supervisor after machine cleared", 1, 0, 3);

        // R7 level order and tie
        line_lvl[3] = 200; line_attr[7] = 2'b01; line_lvl[7] = 10;
        pset(7);
        expect_take("R7 higher level", 1, 0, 3);
        line_lvl[3] = 10; settle();
        expect_take("R7 tie to higher index", 1, 0, 7);
        line_lvl[3] = 200;

        // R8 threshold strictly exceeded
        pclr(3); s_thresh = 10; settle();
        expect_take("R8 level equal to threshold", 0, 0, 0);
        s_thresh = 9; settle();
        expect_take("R8 level above threshold", 1, 0, 7);
        s_thresh = 0;

        // R9 uncleared line retriggers
        s_gie = 0; settle();
        expect_take("R9 masked in handler", 0, 0, 0);
        chk(wake == 1, "R10 wake with pending", wake, 1);
        s_gie = 1; settle();
        expect_take("R9 retrigger", 1, 0, 7);

        // R2 reserved attributes
        line_attr[7] = 2'b00; settle();
        expect_take("R2 attr 00", 0, 0, 0);
        chk(wake == 1, "R10 wake reserved attr", wake, 1);
        line_attr[7] = 2'b10; settle();
        expect_take("R2 attr 10", 0, 0, 0);
        line_attr[7] = 2'b01;
        pclr(7); @(negedge clk);

        // R12 latency
        sw_set[3] = 1; @(negedge clk); sw_set[3] = 0;
        chk(pend_q[3] == 1 && take == 0, "R12 pending before take", take, 0);
        @(negedge clk);
        expect_take("R12 take one cycle later", 1, 0, 3);
        pclr(3); @(negedge clk);

        // R1 edge set, level hold, set beats clear
        line_en[5] = 1; line_attr[5] = 2'b01; line_lvl[5] = 5;
        irq_in[5] = 1; settle();
        chk(pend_q[5] == 1, "R1 edge sets", pend_q[5], 1);
        pclr(5); @(negedge clk);
        chk(pend_q[5] == 0, "R1 held high no reset", pend_q[5], 0);
        irq_in[5] = 0; @(negedge clk);
        sw_set[5] = 1; sw_clr[5] = 1; @(negedge clk);
        sw_set[5] = 0; sw_clr[5] = 0; @(negedge clk);
        chk(pend_q[5] == 1, "R1 set wins", pend_q[5], 1);
        settle();

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule